// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor

This block is a small 32-bit processor core that finishes each instruction in exactly one clock. It has five register-register operations (add, subtract, and, or, signed set-less-than), word load, word store, branch-if-equal and an absolute jump. A register file with 32 entries of 32 bits has two read ports and one write port. A three-line ALU is shared by register arithmetic, address generation and the equality test. Two multiplexers steer the ALU's second operand and the write-back value.

The instruction store and the data store are separate arrays inside the top, so a fetch and a data access can happen in the same cycle. While reset is held, a loader port fills either array. After reset is released, the core runs from address zero. Each committed register write and each store appears on observation ports in the cycle it executes.

Top module: `onecycle_cpu`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and no write-back or store is reported. Every register reads 0 after reset.
- R2: For an instruction that is neither a taken branch nor a jump, the next `pc_o` is the current `pc_o` plus 4.
- R3: Register operations use opcode 0 and write the rd field. The funct field selects the operation: 0x20 add, 0x22 subtract (rs minus rt), 0x24 and, 0x25 or. Any other funct does nothing.
- R4: Set-less-than (funct 0x2A) compares rs with rt as signed numbers and writes 1 or 0.
- R5: A load (opcode 0x23) reads the data word at rs plus the sign-extended 16-bit immediate and writes it to the rt field's register. A negative immediate moves the address down.
- R6: A store (opcode 0x2B) writes rt's value to the data word at rs plus the sign-extended immediate. It reports that address and value and commits no register write.
- R7: Branch-if-equal (opcode 0x04) loads PC+4+4×sign-extended immediate when rs equals rt, and loads PC+4 otherwise. It never writes a register.
- R8: A jump (opcode 0x02) loads the upper four bits of PC+4, then the 26-bit target field, then two zero bits. It never writes a register.
- R9: Register 0 always reads 0. A write aimed at it is dropped and not reported.
- R10: A register write takes effect at the end of its cycle. The next instruction sees the new value, and an instruction that reads its own destination sees the old value.
- R11: While reset is held, the loader writes `ld_data` to word `ld_addr` of the instruction store when `ld_dsel` is 0, or of the data store when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Loader write strobe, honoured only in reset |
| ld_dsel | input | 1 | Loader target: 0 instruction store, 1 data store |
| ld_addr | input | MEM_AW | Loader word index |
| ld_data | input | 32 | Loader write word |
| pc_o | output | 32 | Address of the executing instruction |
| wb_valid | output | 1 | A register write commits this cycle |
| wb_reg | output | 5 | Destination register of the write |
| wb_value | output | 32 | Value written |
| st_valid | output | 1 | A store commits this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_value | output | 32 | Word stored |

## Verification
The program loads operands with opposite signs, so signed and unsigned set-less-than give different answers. The and and or results have partial bit overlap, and the add and subtract results differ in sign. A load with a negative offset separates sign extension from zero extension, and a store followed by a load of the same word confirms the data path through memory. Both branch outcomes are tried, and each skipped slot holds a decoy instruction whose write would show up as a wrong event. A write to register 0, and later reads of it, show that the write was dropped. An instruction that reads and writes the same register shows that write-back lands at the end of the cycle.

// File: rtl/onecycle_cpu.sv
module onecycle_cpu #(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic              ld_dsel,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  output logic [31:0]       pc_o,
  output logic              wb_valid,
  output logic [4:0]        wb_reg,
  output logic [31:0]       wb_value,
  output logic              st_valid,
  output logic [31:0]       st_addr,
  output logic [31:0]       st_value
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [5:0] OP_REG = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B,
                         OP_BEQ = 6'h04, OP_J = 6'h02;
  localparam logic [2:0] A_AND = 3'b000, A_OR = 3'b001, A_ADD = 3'b010,
                         A_SUB = 3'b110, A_SLT = 3'b111;

  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] rf   [32];
  logic [31:0] pc, instr, pc4, sext, rs_val, rt_val, opb, alu_res, pc_next;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, dst;
  logic [2:0]  alu_ctl;
  logic        is_r, is_lw, is_sw, is_beq, is_j, r_ok, reg_wr;
  logic        unused_shamt;

  assign instr = imem[pc[MEM_AW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];
  assign unused_shamt = ^instr[10:6];
  assign sext  = {{16{instr[15]}}, instr[15:0]};

  assign is_r   = op == OP_REG;
  assign is_lw  = op == OP_LW;
  assign is_sw  = op == OP_SW;
  assign is_beq = op == OP_BEQ;
  assign is_j   = op == OP_J;

  always_comb begin
    r_ok    = is_r;
    alu_ctl = A_ADD;
    if (is_beq) alu_ctl = A_SUB;
    else if (is_r)
      case (funct)
        6'h20:   alu_ctl = A_ADD;
        6'h22:   alu_ctl = A_SUB;
        6'h24:   alu_ctl = A_AND;
        6'h25:   alu_ctl = A_OR;
        6'h2A:   alu_ctl = A_SLT;
        default: r_ok = 1'b0;
      endcase
  end

  assign rs_val = rf[rs];
  assign rt_val = rf[rt];
  assign opb    = (is_lw || is_sw) ? sext : rt_val;

  always_comb
    case (alu_ctl)
      A_AND:   alu_res = rs_val & opb;
      A_OR:    alu_res = rs_val | opb;
      A_SUB:   alu_res = rs_val - opb;
      A_SLT:   alu_res = {31'b0, $signed(rs_val) < $signed(opb)};
      default: alu_res = rs_val + opb;
    endcase

  assign pc4     = pc + 32'd4;
  assign pc_next = is_j ? {pc4[31:28], instr[25:0], 2'b00}
                 : (is_beq && alu_res == 32'b0) ? pc4 + {sext[29:0], 2'b00}
                 : pc4;

  assign reg_wr   = r_ok || is_lw;
  assign dst      = is_lw ? rt : rd;
  assign wb_valid = rst_n && reg_wr && dst != 5'd0;
  assign wb_reg   = dst;
  assign wb_value = is_lw ? dmem[alu_res[MEM_AW+1:2]] : alu_res;
  assign st_valid = rst_n && is_sw;
  assign st_addr  = alu_res;
  assign st_value = rt_val;
  assign pc_o     = pc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < 32; i++) rf[i] <= '0;
    else if (wb_valid) rf[wb_reg] <= wb_value;

  always_ff @(posedge clk)
    if (!rst_n) begin
      if (ld_we && !ld_dsel) imem[ld_addr] <= ld_data;
      if (ld_we &&  ld_dsel) dmem[ld_addr] <= ld_data;
    end else if (st_valid) dmem[alu_res[MEM_AW+1:2]] <= st_value;

  AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0] == 32'b0); // R9
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_j && !is_beq) |=> pc == $past(pc) + 32'd4); // R2
  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (is_beq && rs_val == rt_val) |=> pc == $past(pc) + 32'd4 + ($past(sext) << 2)); // R7
  AST_J_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    is_j |=> pc[27:0] == {$past(instr[25:0]), 2'b00}); // R8
  AST_NO_WB_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sw || is_beq || is_j) |-> !wb_valid); // R6
  AST_WB_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> rf[$past(wb_reg)] == $past(wb_value)); // R10
endmodule

// File: tb/test_onecycle_cpu.sv
module test_onecycle_cpu;
  localparam int AW = 6;
  logic clk = 1'b0, rst_n = 1'b0, ld_we = 1'b0, ld_dsel = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0, pc_o, wb_value, st_addr, st_value;
  logic wb_valid, st_valid;
  logic [4:0] wb_reg;
  int checks = 0, fails = 0;
  bit run = 0, done = 0;

  logic [31:0] pc_q[$];
  string       pc_t[$];
  bit          ev_st[$];
  logic [31:0] ev_a[$], ev_d[$];
  string       ev_t[$];

  always #4 clk = ~clk;

  onecycle_cpu #(.MEM_AW(AW)) i_onecycle_cpu (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_dsel(ld_dsel), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_o(pc_o), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .wb_value(wb_value), .st_valid(st_valid), .st_addr(st_addr), .st_value(st_value));

  function automatic logic [31:0] rt_op(int s, int t, int d, logic [5:0] f);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] it_op(logic [5:0] o, int s, int t, logic [15:0] imm);
    return {o, 5'(s), 5'(t), imm};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(bit d, int a, logic [31:0] v);
    @(negedge clk);
    ld_we = 1'b1; ld_dsel = d; ld_addr = AW'(a); ld_data = v;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic exp_pc(int w, string tag);
    pc_q.push_back(32'(w * 4)); pc_t.push_back(tag);
  endtask
  task automatic exp_wb(int r, logic [31:0] v, string tag);
    ev_st.push_back(1'b0); ev_a.push_back(32'(r)); ev_d.push_back(v); ev_t.push_back(tag);
  endtask
  task automatic exp_st(logic [31:0] a, logic [31:0] v, string tag);
    ev_st.push_back(1'b1); ev_a.push_back(a); ev_d.push_back(v); ev_t.push_back(tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (run && pc_q.size() > 0) begin
        chk(pc_t.pop_front(), pc_o, pc_q.pop_front());
        if (wb_valid || st_valid) begin
          if (ev_st.size() == 0) begin
            checks++; fails++;
            $display("FAIL R9 unexpected commit actual=%h expected=none", wb_valid ? 32'(wb_reg) : st_addr);
          end else begin
            automatic bit s = ev_st.pop_front();
            automatic string t = ev_t.pop_front();
            automatic logic [31:0] a = ev_a.pop_front();
            automatic logic [31:0] d = ev_d.pop_front();
            chk({t, " kind"}, {31'b0, st_valid}, {31'b0, s});
            chk({t, " addr"}, st_valid ? st_addr : 32'(wb_reg), a);
            chk({t, " data"}, st_valid ? st_value : wb_value, d);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R11: preload data words while in reset
    load(1, 0, 32'd5);
    load(1, 1, 32'hFFFF_FFFD);
    load(1, 2, 32'h0000_F0F0);
    load(1, 3, 32'h00FF_00FF);
    load(0, 0,  it_op(6'h23, 0, 1, 16'd0));
    load(0, 1,  it_op(6'h23, 0, 2, 16'd4));
    load(0, 2,  it_op(6'h23, 0, 3, 16'd8));
    load(0, 3,  it_op(6'h23, 0, 4, 16'd12));
    load(0, 4,  rt_op(1, 2, 5, 6'h20));
    load(0, 5,  rt_op(1, 2, 6, 6'h22));
    load(0, 6,  rt_op(3, 4, 7, 6'h24));
    load(0, 7,  rt_op(3, 4, 8, 6'h25));
    load(0, 8,  rt_op(2, 1, 9, 6'h2A));
    load(0, 9,  rt_op(1, 2, 10, 6'h2A));
    load(0, 10, rt_op(1, 1, 0, 6'h20));
    load(0, 11, rt_op(0, 1, 11, 6'h20));
    load(0, 12, it_op(6'h2B, 0, 6, 16'd32));
    load(0, 13, it_op(6'h23, 6, 12, 16'hFFFC));
    load(0, 14, it_op(6'h23, 0, 13, 16'd32));
    load(0, 15, it_op(6'h04, 1, 11, 16'd3));
    for (int w = 16; w < 19; w++) load(0, w, rt_op(1, 1, 14, 6'h20));
    load(0, 19, it_op(6'h04, 1, 2, 16'd5));
    load(0, 20, rt_op(13, 13, 14, 6'h20));
    load(0, 21, {6'h02, 26'd24});
    load(0, 22, rt_op(1, 1, 15, 6'h20));
    load(0, 23, rt_op(1, 1, 15, 6'h20));
    load(0, 24, rt_op(13, 1, 15, 6'h20));
    load(0, 25, rt_op(2, 1, 16, 6'h22));
    load(0, 26, rt_op(16, 1, 16, 6'h20));
    load(0, 27, rt_op(19, 20, 18, 6'h20));
    load(0, 28, it_op(6'h04, 0, 0, 16'hFFFF));

    chk("R1 pc in reset", pc_o, 32'd0);
    chk("R1 no commit in reset", {30'b0, wb_valid, st_valid}, 32'd0);

    for (int w = 0; w < 16; w++) exp_pc(w, "R2 sequential pc");
    exp_pc(19, "R7 taken branch");
    exp_pc(20, "R7 not-taken branch");
    exp_pc(21, "R2 sequential pc");
    exp_pc(24, "R8 jump target");
    for (int w = 25; w < 29; w++) exp_pc(w, "R2 sequential pc");
    for (int k = 0; k < 3; k++) exp_pc(28, "R7 backward branch");

    exp_wb(1, 32'd5, "R5 load");
    exp_wb(2, 32'hFFFF_FFFD, "R5 load");
    exp_wb(3, 32'h0000_F0F0, "R5 load");
    exp_wb(4, 32'h00FF_00FF, "R5 load");
    exp_wb(5, 32'd2, "R3 add");
    exp_wb(6, 32'd8, "R3 sub");
    exp_wb(7, 32'h0000_00F0, "R3 and");
    exp_wb(8, 32'h00FF_F0FF, "R3 or");
    exp_wb(9, 32'd1, "R4 slt signed true");
    exp_wb(10, 32'd0, "R4 slt signed false");
    exp_wb(11, 32'd5, "R9 r0 reads zero");
    exp_st(32'd32, 32'd8, "R6 store");
    exp_wb(12, 32'hFFFF_FFFD, "R5 negative offset");
    exp_wb(13, 32'd8, "R6 stored word reloads");
    exp_wb(14, 32'd16, "R7 not-taken path");
    exp_wb(15, 32'd13, "R8 jump landing");
    exp_wb(16, 32'hFFFF_FFF8, "R3 sub negative");
    exp_wb(16, 32'hFFFF_FFFD, "R10 old value read");
    exp_wb(18, 32'd0, "R1 registers cleared");

    @(posedge clk);
    #1 rst_n = 1'b1; run = 1'b1;
    wait (pc_q.size() == 0);
    @(negedge clk);
    chk("R9 all commits seen", 32'(ev_st.size()), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule